// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. It holds the program counter, a 32-word register file with two read ports and one write port, an immediate extender, a three-function ALU, the operand and write-back selectors, and the decode logic that steers them. Instruction memory and data memory live outside the core. Both are read combinationally in the same cycle as the access. Writes to the register file, to the data memory and to the program counter all take effect on the rising clock edge.

The supported set has seven instructions: register add, register subtract, OR with an immediate, word load, word store, branch when equal, and an absolute jump. The opcode decoder produces a coarse ALU class. A second, local decoder turns that class and the function field into the ALU operation. The branch decision uses the ALU zero flag from a subtract of the two register operands.

Top module: `sc_core`

## Requirements
- R1: Opcode 000000 with function field 100000 writes rs+rt into register rd, and with function field 100010 writes rs-rt into rd (wrapping, 32-bit). The fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and function [5:0].
- R2: Opcode 001101 writes rs OR the zero-extended immediate [15:0] into register rt.
- R3: Opcode 100011 reads the data word at rs + sign-extended immediate and writes it into register rt.
- R4: Opcode 101011 drives the address rs + sign-extended immediate, drives register rt as write data and asserts the data write enable for that cycle only. It does not write the register file.
- R5: Opcode 000100 moves the PC to PC+4+(sign-extended immediate × 4) when rs equals rt, and to PC+4 otherwise. It writes neither the registers nor memory.
- R6: Opcode 000010 loads the PC with the upper four bits of PC+4 joined to field [25:0] and two zero bits.
- R7: Register 0 always reads as zero. Writes aimed at it are discarded.
- R8: An active-low reset, asserted asynchronously, sets the PC to 0. The fetch address is always word aligned, and every instruction other than a branch or jump moves the PC forward by 4.
- R9: Any other opcode, and opcode 000000 with any other function field, writes neither the registers nor memory, and the PC moves forward by 4.
- R10: At most one of register write, memory write, branch and jump is active for any instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| imem_addr | output | 32 | Byte address of the instruction to fetch (the PC) |
| imem_data | input | 32 | Instruction word returned combinationally |
| dmem_addr | output | 32 | Byte address for data load or store |
| dmem_wdata | output | 32 | Store data, taken from register rt |
| dmem_we | output | 1 | Data write enable, active for a store |
| dmem_rdata | input | 32 | Load data returned combinationally |

## Verification
The assertions assume that the instruction port returns a defined word for every aligned address the PC can reach, from the first clock after reset onward. They also assume that the data port returns a defined word within the same cycle as the address. The stimulus meets both conditions: the bench backs each port with a fully initialised array indexed by address bits [7:2], and the program holds its PC inside that array by ending in a branch to itself. The program writes each register before it reads it, so no check depends on register contents that reset does not clear.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN     = 32;
  localparam int NREGS    = 32;
  localparam int REG_AW   = $clog2(NREGS);
  localparam int OP_W     = 6;
  localparam int FN_W     = 6;
  localparam int IMM_W    = 16;
  localparam int JT_W     = 26;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OPC_ORI   = 6'b001101;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OPC_JUMP  = 6'b000010;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;

  typedef enum logic [1:0] {
    CLS_ADD = 2'd0,
    CLS_SUB = 2'd1,
    CLS_OR  = 2'd2,
    CLS_REG = 2'd3
  } alu_class_e;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_fn_e;

  typedef struct packed {
    logic       dst_is_rd;
    logic       opb_is_imm;
    logic       wb_from_mem;
    logic       reg_we;
    logic       mem_we;
    logic       branch;
    logic       jump;
    logic       ext_sign;
    alu_class_e alu_cls;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] funct,
  output ctrl_t           ctrl,
  output alu_fn_e         alu_fn
);
  logic fn_known;

  always_comb begin
    ctrl = '0;
    ctrl.alu_cls = CLS_ADD;
    case (opcode)
      OPC_RTYPE: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.reg_we    = fn_known;
        ctrl.alu_cls   = CLS_REG;
      end
      OPC_ORI: begin
        ctrl.opb_is_imm = 1'b1;
        ctrl.reg_we     = 1'b1;
        ctrl.alu_cls    = CLS_OR;
      end
      OPC_LOAD: begin
        ctrl.opb_is_imm  = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.reg_we      = 1'b1;
        ctrl.ext_sign    = 1'b1;
      end
      OPC_STORE: begin
        ctrl.opb_is_imm = 1'b1;
        ctrl.mem_we     = 1'b1;
        ctrl.ext_sign   = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch  = 1'b1;
        ctrl.alu_cls = CLS_SUB;
      end
      OPC_JUMP: ctrl.jump = 1'b1;
      default: ;
    endcase
  end

  // local ALU decode: class from the opcode, detail from the function field
  always_comb begin
    fn_known = 1'b0;
    alu_fn   = ALU_ADD;
    unique case (ctrl.alu_cls)
      CLS_SUB: alu_fn = ALU_SUB;
      CLS_OR:  alu_fn = ALU_OR;
      CLS_REG: begin
        if (funct == FN_SUB) alu_fn = ALU_SUB;
        fn_known = (funct == FN_ADD) || (funct == FN_SUB);
      end
      default: alu_fn = ALU_ADD;
    endcase
  end

  always_comb begin
    assert_ctrl_excl_R10: assert ($onehot0({ctrl.reg_we, ctrl.mem_we, ctrl.branch, ctrl.jump}));
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int N  = NREGS,
  localparam int AW = $clog2(N)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs_q [1:N-1];

  genvar gi;
  generate
    for (gi = 1; gi < N; gi++) begin : g_reg
      logic en;
      assign en = we && (wa == AW'(gi));
      always_ff @(posedge clk) begin
        if (en) regs_q[gi] <= wd;
      end
    end
  endgenerate

  assign rd_a = (ra_a == '0) ? '0 : regs_q[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs_q[ra_b];

  assert_r0_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_a == '0) |-> (rd_a == '0));
  assert_wb_visible_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wa != '0 && !(ra_a == wa && $isunknown(wd))) ##1 (ra_a == $past(wa)) |->
      (rd_a == $past(wd)));
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = XLEN
)(
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  alu_fn_e      fn,
  output logic [W-1:0] res,
  output logic         zero
);
  always_comb begin
    unique case (fn)
      ALU_SUB: res = opa - opb;
      ALU_OR:  res = opa | opb;
      default: res = opa + opb;
    endcase
  end
  assign zero = (res == '0);
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_data,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);
  localparam int PAD = XLEN - IMM_W;

  logic [XLEN-1:0]   pc_q, pc_d, pc_inc, br_tgt, jmp_tgt;
  logic              pc_en;
  logic [OP_W-1:0]   opc;
  logic [REG_AW-1:0] rs, rt, rd, wa;
  logic [IMM_W-1:0]  imm;
  ctrl_t             ctrl;
  alu_fn_e           alu_fn;
  logic [XLEN-1:0]   bus_a, bus_b, ext_imm, opb, alu_res, wb;
  logic              alu_zero, take_br;

  assign opc = imem_data[31:26];
  assign rs  = imem_data[25:21];
  assign rt  = imem_data[20:16];
  assign rd  = imem_data[15:11];
  assign imm = imem_data[15:0];

  sc_decode u_dec (
    .opcode (opc),
    .funct  (imem_data[5:0]),
    .ctrl   (ctrl),
    .alu_fn (alu_fn)
  );

  assign wa = ctrl.dst_is_rd ? rd : rt;

  sc_regfile #(.W(XLEN), .N(NREGS)) u_rf (
    .clk  (clk),
    .rst_n(rst_n),
    .ra_a (rs),
    .ra_b (rt),
    .rd_a (bus_a),
    .rd_b (bus_b),
    .we   (ctrl.reg_we),
    .wa   (wa),
    .wd   (wb)
  );

  assign ext_imm = ctrl.ext_sign ? {{PAD{imm[IMM_W-1]}}, imm} : {{PAD{1'b0}}, imm};
  assign opb     = ctrl.opb_is_imm ? ext_imm : bus_b;

  sc_alu #(.W(XLEN)) u_alu (
    .opa (bus_a),
    .opb (opb),
    .fn  (alu_fn),
    .res (alu_res),
    .zero(alu_zero)
  );

  assign wb         = ctrl.wb_from_mem ? dmem_rdata : alu_res;
  assign dmem_addr  = alu_res;
  assign dmem_wdata = bus_b;
  assign dmem_we    = ctrl.mem_we;

  // next PC
  assign pc_inc  = pc_q + XLEN'(4);
  assign br_tgt  = pc_inc + {{(PAD-2){imm[IMM_W-1]}}, imm, 2'b00};
  assign jmp_tgt = {pc_inc[XLEN-1:XLEN-4], imem_data[JT_W-1:0], 2'b00};
  assign take_br = ctrl.branch && alu_zero;
  assign pc_en   = 1'b1;

  always_comb begin
    pc_d = pc_q;
    if (pc_en) begin
      if (ctrl.jump)    pc_d = jmp_tgt;
      else if (take_br) pc_d = br_tgt;
      else              pc_d = pc_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign imem_addr = pc_q;

  assert_pc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (opc != OPC_BEQ && opc != OPC_JUMP) |=> (imem_addr == $past(imem_addr) + 32'd4));
  assert_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    imem_addr[1:0] == 2'b00);
  assert_beq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_BEQ) |-> (!dmem_we && !ctrl.reg_we));
  assert_beq_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_BEQ && bus_a == bus_b) |=>
      (imem_addr == $past(imem_addr) + 32'd4 +
        {{14{$past(imem_data[15])}}, $past(imem_data[15:0]), 2'b00}));
  assert_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_STORE) |-> (dmem_we && !ctrl.reg_we));
  assert_unsup_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (opc != OPC_RTYPE && opc != OPC_ORI && opc != OPC_LOAD &&
     opc != OPC_STORE && opc != OPC_BEQ && opc != OPC_JUMP) |-> (!dmem_we && !ctrl.reg_we));
endmodule

// File: tb/sc_core_test.sv
module sc_core_test;
  logic        clk;
  logic        rst_n;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [0:63];
  logic [31:0] dmem [0:63];

  int n_chk  = 0;
  int n_fail = 0;

  typedef struct packed { logic [31:0] a; logic [31:0] d; } exp_t;
  exp_t exp_q[$];

  sc_core uut (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
  end

  function automatic logic [31:0] r_ins(input int s, input int t, input int d, input logic [5:0] f);
    return {6'b000000, 5'(s), 5'(t), 5'(d), 5'b00000, f};
  endfunction
  function automatic logic [31:0] i_ins(input logic [5:0] op, input int s, input int t, input logic [15:0] im);
    return {op, 5'(s), 5'(t), im};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_store(input logic [31:0] a, input logic [31:0] d);
    exp_q.push_back({a, d});
  endtask

  // monitor: each store seen at the data port is compared with the next expected one
  always @(negedge clk) begin
    if (rst_n && dmem_we) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R4 unexpected store actual=%h/%h expected=none", dmem_addr, dmem_wdata);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check("R4 store address", dmem_addr, e.a);
        check("R4 store data", dmem_wdata, e.d);
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'hFC00_0000;
      dmem[i] = 32'h0;
    end
    dmem[14] = 32'hCAFE_F00D;
    imem[0]  = i_ins(6'b001101, 0, 1, 16'h0005);
    imem[1]  = i_ins(6'b001101, 0, 2, 16'h0003);
    imem[2]  = r_ins(1, 2, 3, 6'b100000);
    imem[3]  = r_ins(1, 2, 4, 6'b100010);
    imem[4]  = i_ins(6'b101011, 0, 3, 16'h0010);
    imem[5]  = i_ins(6'b101011, 0, 4, 16'h0014);
    imem[6]  = i_ins(6'b001101, 0, 5, 16'hFFFF);
    imem[7]  = i_ins(6'b101011, 0, 5, 16'h0018);
    imem[8]  = i_ins(6'b001101, 0, 0, 16'h1234);
    imem[9]  = i_ins(6'b101011, 0, 0, 16'h001C);
    imem[10] = i_ins(6'b100011, 0, 6, 16'h0010);
    imem[11] = r_ins(6, 6, 7, 6'b100000);
    imem[12] = i_ins(6'b101011, 0, 7, 16'h0020);
    imem[13] = i_ins(6'b001101, 0, 8, 16'h0040);
    imem[14] = i_ins(6'b101011, 8, 1, 16'hFFFC);
    imem[15] = i_ins(6'b000100, 1, 2, 16'h0005);
    imem[16] = i_ins(6'b101011, 0, 2, 16'h0024);
    imem[17] = i_ins(6'b000100, 1, 1, 16'h0001);
    imem[18] = i_ins(6'b101011, 0, 1, 16'h0028);
    imem[19] = {6'b000010, 26'd21};
    imem[20] = i_ins(6'b101011, 0, 1, 16'h002C);
    imem[21] = r_ins(2, 1, 9, 6'b100010);
    imem[22] = i_ins(6'b101011, 0, 9, 16'h0030);
    imem[23] = i_ins(6'b100011, 8, 10, 16'hFFF8);
    imem[24] = i_ins(6'b101011, 0, 10, 16'h0034);
    imem[25] = r_ins(2, 2, 1, 6'b100100);
    imem[26] = i_ins(6'b101011, 0, 1, 16'h0040);
    imem[27] = i_ins(6'b000100, 0, 0, 16'hFFFF);

    push_store(32'h10, 32'd8);          // R1 add
    push_store(32'h14, 32'd2);          // R1 sub
    push_store(32'h18, 32'h0000_FFFF);  // R2 zero extension
    push_store(32'h1C, 32'h0);          // R7 write to r0 discarded
    push_store(32'h20, 32'd16);         // R3 load then add
    push_store(32'h3C, 32'd5);          // R4 negative offset
    push_store(32'h24, 32'd3);          // R5 branch not taken
    push_store(32'h30, 32'hFFFF_FFFE);  // R1 sub wraps
    push_store(32'h34, 32'hCAFE_F00D);  // R3 negative offset load
    push_store(32'h40, 32'd5);          // R9 unknown function leaves r1

    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset pc", imem_addr, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 pc step", imem_addr, 32'h4);

    begin
      int cyc = 0;
      while ((exp_q.size() != 0 || imem_addr != 32'h6C) && cyc < 500) begin
        @(negedge clk);
        cyc++;
      end
      if (cyc >= 500) begin
        n_chk++; n_fail++;
        $display("FAIL R8 watchdog actual=%h expected=%h", imem_addr, 32'h6C);
      end
    end
    repeat (4) @(negedge clk);
    check("R5 self-branch holds pc", imem_addr, 32'h6C);
    check("R5 taken branch skipped store", dmem[10], 32'h0);
    check("R6 jump skipped store", dmem[11], 32'h0);
    check("R4 memory holds stored word", dmem[4], 32'd8);
    check("R9 no stores left pending", 32'(exp_q.size()), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule